// File: doc/BRIEF.md
# Byte-Accessed Timer Capture/Compare Register

This block holds the 16-bit match value or captured count of one timer channel. Software reaches it over an 8-bit register bus as two byte addresses, low and high. In compare and PWM modes, software writes the low byte and then the high byte. The high-byte write is the event that moves the assembled 16-bit word into the internal compare register, which drives the timer's comparator. In PWM mode that transfer is held pending until the running PWM period ends, so a period is never cut short by a half-updated match value.

In capture mode the byte registers are read-only. A pulse on the capture trigger copies the running counter into an internal capture register. Reading the low byte returns the lower half of the captured word and, at the same edge, freezes the upper half into a latch. A later high-byte read therefore returns the half that matches, even if another capture has happened in between. The counter, the trigger edge selection and interrupt logic sit outside this block.

Top module: `capcmp_reg`

## Requirements
- R1: After reset, `compareVal` is 0. Reads of either byte return 0 in every mode, and no load is pending.
- R2: When `modeSel` is 00 (compare), a write to the high byte (`busAddr`=1) sets `compareVal` to {written byte, stored low byte} on the clock edge that takes the write.
- R3: A write to the low byte (`busAddr`=0) alone never changes `compareVal`.
- R4: When `modeSel` is 01 (PWM), a high-byte write does not change `compareVal`. Instead, the value {written byte, stored low byte} is held pending. It reaches `compareVal` on the first later edge at which `pwmCycleEnd` is 1.
- R5: In PWM mode, a second high-byte write before the period ends replaces the pending value. Only the latest pending value is loaded.
- R6: In PWM mode, a high-byte write in the same cycle as `pwmCycleEnd` works as follows. The value that was already pending, if any, is loaded. The new value stays pending for the next period end.
- R7: In compare or PWM mode, `busRdData` returns the last byte written to the selected address, whether or not that byte has reached `compareVal`.
- R8: When `modeSel[1]` is 1 (capture), a `captureTrig` pulse copies `counterVal` into the capture register. A low-byte read returns the capture register's bits 7:0.
- R9: In capture mode, a low-byte read (`busRdEn` with `busAddr`=0) latches capture bits 15:8. High-byte reads then return that latched byte until the next low-byte read.
- R10: In capture mode, bus writes are ignored. `compareVal` and the stored byte values seen on return to compare mode are unchanged.
- R11: If a capture trigger and a low-byte read fall in the same cycle, the read returns the old capture low byte and the latch takes the old high byte.
- R12: `captureTrig` has no effect outside capture mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busAddr | input | 1 | Byte select: 0 low, 1 high |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational from address |
| modeSel | input | 2 | 00 compare, 01 PWM, 1x capture |
| counterVal | input | 16 | Running timer count |
| captureTrig | input | 1 | Capture trigger pulse |
| pwmCycleEnd | input | 1 | End-of-PWM-period pulse |
| compareVal | output | 16 | Internal compare register |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a PWM period end and a high-byte write. The bench provokes it with a directed case and checks that the older pending value is loaded while the new one waits for the next end (R6). The second pair is a capture trigger and a low-byte read. The bench checks that the returned low byte and the later high-byte read both come from the previous capture (R11). Random traffic also lets both pairs collide, and a cycle-level model in the bench judges every outcome.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    MODE_CMP  = 2'b00,
    MODE_PWM  = 2'b01,
    MODE_CAP  = 2'b10,
    MODE_CAP2 = 2'b11
  } modeE;

  // strobes from control to datapath
  typedef struct packed {
    logic wrLo;       // store low byte buffer
    logic wrHi;       // store high byte buffer
    logic cmpDirect;  // compare mode: commit {hi,lo} now
    logic pendStage;  // PWM mode: stage {hi,lo} as pending
    logic pendLoad;   // PWM mode: move pending into compare
    logic capTake;    // sample counter into capture register
    logic hiLatch;    // freeze capture upper byte
    logic selCap;     // read mux picks capture side
  } strobeT;
endpackage

// File: rtl/capcmp_ctrl.sv
module capcmp_ctrl
  import capcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       busWrEn,
  input  logic       busRdEn,
  input  logic       busAddr,
  input  logic       captureTrig,
  input  logic       pwmCycleEnd,
  output strobeT     stb
);
  logic capMode, pwmMode, cmpMode;
  logic pendValid;

  assign capMode = modeSel[1];
  assign pwmMode = (modeE'(modeSel) == MODE_PWM);
  assign cmpMode = (modeE'(modeSel) == MODE_CMP);

  always_comb begin
    stb           = '0;
    stb.wrLo      = !capMode && busWrEn && !busAddr;
    stb.wrHi      = !capMode && busWrEn && busAddr;
    stb.cmpDirect = cmpMode && busWrEn && busAddr;
    stb.pendStage = pwmMode && busWrEn && busAddr;
    stb.pendLoad  = pwmMode && pwmCycleEnd && pendValid;
    stb.capTake   = capMode && captureTrig;
    stb.hiLatch   = capMode && busRdEn && !busAddr;
    stb.selCap    = capMode;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pendValid <= 1'b0;
    else if (stb.pendStage) pendValid <= 1'b1;
    else if (stb.pendLoad)  pendValid <= 1'b0;
    else if (stb.cmpDirect) pendValid <= 1'b0;
  end

  p_stage_sets_pending_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendStage |=> pendValid);
  p_load_only_when_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendLoad |-> pendValid);
  p_load_clears_pending_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.pendLoad && !stb.pendStage) |=> !pendValid);
  p_no_trigger_outside_capture_r12: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel[1] |-> !stb.capTake);
endmodule

// File: rtl/capcmp_dp.sv
module capcmp_dp
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic [WORD_W-1:0] counterVal,
  output logic [BYTE_W-1:0] busRdData,
  output logic [WORD_W-1:0] compareVal
);
  logic [BYTE_W-1:0] loBuf, hiBuf, hiHold;
  logic [WORD_W-1:0] pendReg, cmpReg, capReg;
  logic [WORD_W-1:0] assembled;

  assign assembled = {busWrData, loBuf};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loBuf <= '0;
      hiBuf <= '0;
    end else begin
      if (stb.wrLo) loBuf <= busWrData;
      if (stb.wrHi) hiBuf <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg <= '0;
      cmpReg  <= '0;
    end else begin
      if (stb.pendStage)      pendReg <= assembled;
      if (stb.cmpDirect)      cmpReg  <= assembled;
      else if (stb.pendLoad)  cmpReg  <= pendReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capReg <= '0;
      hiHold <= '0;
    end else begin
      if (stb.capTake) capReg <= counterVal;
      if (stb.hiLatch) hiHold <= capReg[WORD_W-1:BYTE_W];
    end
  end

  always_comb begin
    if (stb.selCap) busRdData = busAddr ? hiHold : capReg[BYTE_W-1:0];
    else            busRdData = busAddr ? hiBuf  : loBuf;
  end

  assign compareVal = cmpReg;

  p_lo_write_keeps_compare_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrLo && !stb.pendLoad) |=> $stable(cmpReg));
  p_capture_samples_counter_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.capTake |=> capReg == $past(counterVal));
  p_latch_takes_old_high_r11: assert property (@(posedge clk) disable iff (!rstN)
    stb.hiLatch |=> hiHold == $past(capReg[WORD_W-1:BYTE_W]));
  p_direct_commit_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.cmpDirect |=> cmpReg == {$past(busWrData), $past(loBuf)});
endmodule

// File: rtl/capcmp_reg.sv
module capcmp_reg
  import capcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic [1:0]        modeSel,
  input  logic [WORD_W-1:0] counterVal,
  input  logic              captureTrig,
  input  logic              pwmCycleEnd,
  output logic [WORD_W-1:0] compareVal
);
  strobeT stb;

  capcmp_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busAddr(busAddr), .captureTrig(captureTrig),
    .pwmCycleEnd(pwmCycleEnd), .stb(stb)
  );

  capcmp_dp dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr),
    .busWrData(busWrData), .counterVal(counterVal),
    .busRdData(busRdData), .compareVal(compareVal)
  );

  p_capture_mode_freezes_compare_r10: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> $stable(compareVal));
  p_pwm_write_defers_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b01 && !pwmCycleEnd) |=> $stable(compareVal));
endmodule

// File: tb/capcmp_reg_tb.sv
module capcmp_reg_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 0, busRdEn = 0, busAddr = 0;
  logic [7:0]  busWrData = 0;
  logic [7:0]  busRdData;
  logic [1:0]  modeSel = 0;
  logic [15:0] counterVal = 0;
  logic        captureTrig = 0, pwmCycleEnd = 0;
  logic [15:0] compareVal;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference model state
  logic [7:0]  mLo = 0, mHi = 0, mLatch = 0;
  logic [15:0] mCmp = 0, mPend = 0, mCap = 0;
  bit          mPendV = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capcmp_reg dut_i (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(logic a, logic [1:0] m);
    if (m[1]) return a ? mLatch : mCap[7:0];
    return a ? mHi : mLo;
  endfunction

  function automatic string rdTag(logic a, logic [1:0] m);
    if (!m[1]) return "R7 read";
    return a ? "R9 latched high read" : "R8 capture low read";
  endfunction

  // one bus cycle: drive after negedge, check read, clock, update model, check compare
  task automatic cyc(bit wr, bit rd, bit a, logic [7:0] d, logic [1:0] m,
                     bit trig, bit pend);
    logic [7:0]  nLo, nHi, nLatch;
    logic [15:0] nCmp, nPend, nCap;
    bit nPendV;
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d; modeSel = m;
    captureTrig = trig; pwmCycleEnd = pend; counterVal = counterVal + 16'd7;
    #1;
    if (rd) check(rdTag(a, m), {8'h0, busRdData}, {8'h0, expRead(a, m)});
    nLo = mLo; nHi = mHi; nLatch = mLatch; nCmp = mCmp; nPend = mPend;
    nCap = mCap; nPendV = mPendV;
    if (m[1]) begin
      if (rd && !a) nLatch = mCap[15:8];
      if (trig) nCap = counterVal;
    end else begin
      if (m == 2'b01 && pend && mPendV) begin nCmp = mPend; nPendV = 0; end
      if (wr && !a) nLo = d;
      if (wr && a) begin
        nHi = d;
        if (m == 2'b00) begin nCmp = {d, mLo}; nPendV = 0; end
        else begin nPend = {d, mLo}; nPendV = 1; end
      end
    end
    @(posedge clk);
    mLo = nLo; mHi = nHi; mLatch = nLatch; mCmp = nCmp; mPend = nPend;
    mCap = nCap; mPendV = nPendV;
    #1;
    check("R2 R4 compareVal", compareVal, mCmp);
    busWrEn = 0; busRdEn = 0; captureTrig = 0; pwmCycleEnd = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 compareVal", compareVal, 16'h0);
    check("R1 low read", {8'h0, busRdData}, 16'h0);
    rstN = 1'b1;

    // R2/R3 compare mode
    cyc(1, 0, 0, 8'h34, 2'b00, 0, 0);
    check("R3 low write only", compareVal, 16'h0000);
    cyc(1, 0, 1, 8'h12, 2'b00, 0, 0);
    check("R2 direct commit", compareVal, 16'h1234);
    cyc(0, 1, 1, 8'h00, 2'b00, 0, 0);
    cyc(0, 1, 0, 8'h00, 2'b00, 0, 0);  // R7 read-back
    // R12 trigger outside capture
    cyc(0, 0, 0, 8'h00, 2'b00, 1, 0);
    cyc(0, 1, 0, 8'h00, 2'b10, 0, 0);
    check("R12 capture untouched", {8'h0, busRdData}, 16'h0000);

    // R4/R5 PWM mode
    cyc(1, 0, 0, 8'hCD, 2'b01, 0, 0);
    cyc(1, 0, 1, 8'hAB, 2'b01, 0, 0);
    check("R4 deferred", compareVal, 16'h1234);
    cyc(1, 0, 1, 8'hEF, 2'b01, 0, 0);
    cyc(0, 1, 1, 8'h00, 2'b01, 0, 0);  // R7 pending value read back
    cyc(0, 0, 0, 8'h00, 2'b01, 0, 1);
    check("R5 latest pending loaded", compareVal, 16'hEFCD);
    // R6 write coinciding with period end
    cyc(1, 0, 1, 8'h11, 2'b01, 0, 0);
    cyc(1, 0, 1, 8'h22, 2'b01, 0, 1);
    check("R6 old pending loaded", compareVal, 16'h11CD);
    cyc(0, 0, 0, 8'h00, 2'b01, 0, 1);
    check("R6 new value next end", compareVal, 16'h22CD);

    // R8/R9/R10/R11 capture mode
    cyc(0, 0, 0, 8'h00, 2'b10, 1, 0);
    cyc(1, 0, 0, 8'h99, 2'b10, 0, 0);
    cyc(1, 0, 1, 8'h99, 2'b11, 0, 0);
    check("R10 writes ignored", compareVal, 16'h22CD);
    cyc(0, 1, 0, 8'h00, 2'b10, 1, 0);  // R11 read with trigger
    cyc(0, 1, 1, 8'h00, 2'b10, 0, 0);  // R11 latch holds old high byte
    cyc(0, 1, 0, 8'h00, 2'b00, 0, 0);
    check("R10 low buffer kept", {8'h0, busRdData}, 16'h00CD);

    // random traffic in mode segments
    for (int s = 0; s < 40; s++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      for (int i = 0; i < 50; i++)
        cyc(($urandom % 3) == 0, ($urandom % 2) == 0, 1'($urandom),
            8'($urandom), m, ($urandom % 4) == 0, ($urandom % 6) == 0);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule